// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets a host controller read and write a bank of sixteen 8-bit registers over four wires: an active-low chip select, a serial clock, serial data in and serial data out. The serial pins are sampled by the system clock through synchronizers, so the host's serial timing does not need any relation to the system clock as long as each serial clock phase lasts several system clock periods.

Each transfer opens with an 8-bit command word shifted in least significant bit first. The command holds a read/write flag, a register address, two bits that must be zero and a burst flag. Data bytes follow, also least significant bit first. A single transfer moves one byte at the addressed register. A burst transfer walks through the whole bank from register 0 upwards. Register 0 holds status. Logic beside the block loads it through a parallel port, and serial writes cannot change it. The contents of all registers are always visible on a flat parallel output for the logic that uses them.

Top module: `serial_reg_port`

## Requirements
- R1: `sdo_oe` is 0 whenever chip select is inactive (`cs_n` high) and becomes 1 within a few system clocks after `cs_n` goes low, so the data output is tri-stated between transfers.
- R2: The first byte of every transfer is a command word. Its bit 0, the first bit shifted in, is 1 for read and 0 for write. Bits 4:1 are the register address, least significant bit first. Bits 6:5 must be zero. Bit 7 selects burst mode.
- R3: `sdi` is sampled on rising edges of `sclk`. `sdo` changes only after a falling edge of `sclk` and holds its value through the high phase that follows.
- R4: A write updates its target register only after all eight data bits have been received. Data bytes are taken least significant bit first.
- R5: In a read, the falling edge after the command's last bit drives bit 0 of the addressed register on `sdo`. The following falling edges drive the higher bits in order.
- R6: In burst mode the address field is ignored. Transfers start at register 0 and the address rises by one after each byte. After register 15 the transfer ends, and any further bytes have no effect.
- R7: Register 0 is read-only from the serial side. Serial writes to it are dropped, including inside a burst. It loads `status_in` on any clock with `status_we` high.
- R8: A command with either reserved bit set turns the rest of the transfer into a no-op. No register changes until chip select rises.
- R9: Raising chip select aborts a transfer in progress and clears the bit count. A partially received data byte is discarded, and the next transfer decodes a fresh command.
- R10: After reset every register reads 0, `sdo` is 0 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle high |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| status_we | input | 1 | Load strobe for the status register |
| status_in | input | 8 | Value loaded into the status register |
| reg_q | output | 128 | All registers, register n in bits 8n+7:8n |

## Verification
The assertions assume that the host keeps each serial clock phase longer than the synchronizer delay plus one clock, so every edge is seen as a single rise or fall event. They also assume that `sdi` does not change in the same system clock as a rising `sclk`. The stimulus holds each phase of `sclk` for eight system clocks and changes `sdi` only while `sclk` is low. Chip select and `status_we` are driven on falling system clock edges, so they meet the synchronizer and register inputs cleanly.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int ADDR_W = 4;
    localparam int NREG   = 2 ** ADDR_W;
    localparam int DATA_W = 8;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int CMD_W  = 1 + ADDR_W + 2 + 1;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_IDLE = 2'd3
    } phase_e;

    typedef struct packed {
        logic              burst;
        logic [1:0]        rsv;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } cmd_t;

    typedef struct packed {
        phase_e            phase;
        logic [BIT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] tx;
        logic [ADDR_W-1:0] addr;
        logic              burst;
        logic              sdo;
        logic              oe;
    } ctrl_t;

endpackage

// File: rtl/srp_edge_sync.sv
module srp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sel,
    output logic rise,
    output logic fall,
    output logic din
);
    localparam int NCH = 3;
    localparam logic [NCH-1:0] IDLE_VAL = 3'b011;

    typedef struct packed {
        logic [STAGES-1:0][NCH-1:0] pipe;
        logic                       sclk_prev;
    } sync_t;

    sync_t s_d, s_q;
    logic [NCH-1:0] raw;
    logic [NCH-1:0] synced;

    assign raw    = {sdi, sclk, cs_n};
    assign synced = s_q.pipe[STAGES-1];

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.sclk_prev = synced[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pipe      <= {STAGES{IDLE_VAL}};
            s_q.sclk_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel  = !synced[0];
    assign rise = synced[1] && !s_q.sclk_prev;
    assign fall = !synced[1] && s_q.sclk_prev;
    assign din  = synced[2];

endmodule

// File: rtl/srp_frame_ctrl.sv
module srp_frame_ctrl
    import srp_pkg::*;
#(
    parameter int STATUS_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NREG - 1);
    localparam logic [ADDR_W-1:0] RO_ADDR   = ADDR_W'(STATUS_ADDR);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);

    ctrl_t c_d, c_q;
    logic [DATA_W-1:0] rx_word;
    cmd_t cmd;
    logic  more;

    assign rx_word = {din, c_q.sh[DATA_W-1:1]};
    assign cmd     = cmd_t'(rx_word[CMD_W-1:0]);
    assign more    = c_q.burst && (c_q.addr != LAST_ADDR);

    always_comb begin
        c_d     = c_q;
        wr_en   = 1'b0;
        wr_addr = c_q.addr;
        wr_data = rx_word;
        if (c_q.phase == PH_CMD) begin
            rd_addr = cmd.burst ? '0 : cmd.addr;
        end else begin
            rd_addr = c_q.addr + 1'b1;
        end
        c_d.oe = sel;

        if (!sel) begin
            c_d.phase = PH_CMD;
            c_d.cnt   = '0;
        end else begin
            if (fall && c_q.phase == PH_RD) begin
                c_d.sdo = c_q.tx[0];
                c_d.tx  = {1'b0, c_q.tx[DATA_W-1:1]};
            end
            if (rise) begin
                c_d.sh  = rx_word;
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt == LAST_BIT) begin
                    unique case (c_q.phase)
                        PH_CMD: begin
                            if (cmd.rsv != 2'b00) begin
                                c_d.phase = PH_IDLE;
                            end else begin
                                c_d.addr  = rd_addr;
                                c_d.burst = cmd.burst;
                                if (cmd.rd) begin
                                    c_d.phase = PH_RD;
                                    c_d.tx    = rd_data;
                                end else begin
                                    c_d.phase = PH_WR;
                                end
                            end
                        end
                        PH_WR: begin
                            wr_en = (c_q.addr != RO_ADDR);
                            if (more) begin
                                c_d.addr = c_q.addr + 1'b1;
                            end else begin
                                c_d.phase = PH_IDLE;
                            end
                        end
                        PH_RD: begin
                            if (more) begin
                                c_d.addr = c_q.addr + 1'b1;
                                c_d.tx   = rd_data;
                            end else begin
                                c_d.phase = PH_IDLE;
                            end
                        end
                        default: c_d.phase = PH_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{phase: PH_CMD, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign sdo    = c_q.sdo;
    assign sdo_oe = c_q.oe;

    // R3: serial output moves only on a falling serial clock
    p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(sdo));

    // R8: a rejected command never writes
    p_ignored_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_IDLE) |-> !wr_en);

    // R6: within a data phase the address never goes backwards
    p_addr_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && (c_q.phase == PH_WR || c_q.phase == PH_RD)) |=> (c_q.addr >= $past(c_q.addr)));

endmodule

// File: rtl/srp_reg_bank.sv
module srp_reg_bank
    import srp_pkg::*;
#(
    parameter int STATUS_ADDR = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     st_we,
    input  logic [DATA_W-1:0]        st_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NREG*DATA_W-1:0]   regs_flat
);
    logic [NREG-1:0][DATA_W-1:0] regs_d, regs_q;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (i == STATUS_ADDR) begin : g_ro
            always_comb regs_d[i] = st_we ? st_data : regs_q[i];
        end else begin : g_rw
            always_comb regs_d[i] = (wr_en && wr_addr == ADDR_W'(i)) ? wr_data : regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data   = regs_q[rd_addr];
    assign regs_flat = regs_q;

    // R7: the serial side never addresses the status slot for writing
    p_status_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != ADDR_W'(STATUS_ADDR)));

    // R7: status slot holds unless its own strobe fires
    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_we |=> $stable(regs_q[STATUS_ADDR]));

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STATUS_ADDR = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   sclk,
    input  logic                   sdi,
    output logic                   sdo,
    output logic                   sdo_oe,
    input  logic                   status_we,
    input  logic [DATA_W-1:0]      status_in,
    output logic [NREG*DATA_W-1:0] reg_q
);
    logic              s_sel, s_rise, s_fall, s_din;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              bank_we;

    srp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .sel   (s_sel),
        .rise  (s_rise),
        .fall  (s_fall),
        .din   (s_din)
    );

    srp_frame_ctrl #(.STATUS_ADDR(STATUS_ADDR)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (s_sel),
        .rise    (s_rise),
        .fall    (s_fall),
        .din     (s_din),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (bank_we),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    srp_reg_bank #(.STATUS_ADDR(STATUS_ADDR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_we),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .st_we     (status_we),
        .st_data   (status_in),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (reg_q)
    );

    // R1: the output driver is released once chip select is seen inactive
    p_oe_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !s_sel |=> !sdo_oe);

    // R4: a register commit only happens on a sampling edge of a selected transfer
    p_commit_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> (s_rise && s_sel));

endmodule

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
    localparam int HP = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b1;
    logic         sdi = 1'b0;
    logic         sdo, sdo_oe;
    logic         status_we = 1'b0;
    logic [7:0]   status_in = 8'h00;
    logic [127:0] reg_q;

    logic [7:0] mdl [16];
    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_reg_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .status_we (status_we),
        .status_in (status_in),
        .reg_q     (reg_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of the register image against the model (R4 R7 R8 R9)
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            int bad = -1;
            for (int r = 0; r < 16; r++) begin
                if (bad < 0 && reg_q[r*8 +: 8] !== mdl[r]) bad = r;
            end
            if (bad >= 0) check(1'b0, "R4/R7/R8 image", int'(reg_q[bad*8 +: 8]), int'(mdl[bad]));
            else          check(sdo_oe === 1'b0, "R1 idle oe", int'(sdo_oe), 0);
        end
    end

    task automatic bit_xfer(input logic b, output logic lo, output logic hi);
        @(negedge clk);
        sclk = 1'b0;
        sdi  = b;
        repeat (HP) @(negedge clk);
        lo = sdo;
        sclk = 1'b1;
        repeat (HP) @(negedge clk);
        hi = sdo;
    endtask

    task automatic byte_xfer(input logic [7:0] v, output logic [7:0] r, output bit steady);
        logic lo, hi;
        steady = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(v[i], lo, hi);
            r[i] = lo;
            if (lo !== hi) steady = 1'b0;
        end
    endtask

    task automatic begin_xfer();
        cmp_en = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        check(sdo_oe === 1'b1, "R1 oe active", int'(sdo_oe), 1);
    endtask

    task automatic end_xfer();
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    function automatic logic [7:0] mk_cmd(input bit rd, input int addr, input bit burst, input logic [1:0] rsv);
        return {burst, rsv, 4'(addr), rd};
    endfunction

    task automatic wr1(input int addr, input logic [7:0] v);
        logic [7:0] r;
        bit s;
        begin_xfer();
        byte_xfer(mk_cmd(1'b0, addr, 1'b0, 2'b00), r, s);
        byte_xfer(v, r, s);
        end_xfer();
        if (addr != 0) mdl[addr] = v;
    endtask

    task automatic rd1(input int addr, input string req);
        logic [7:0] r;
        bit s;
        begin_xfer();
        byte_xfer(mk_cmd(1'b1, addr, 1'b0, 2'b00), r, s);
        byte_xfer(8'h00, r, s);
        check(r === mdl[addr], req, int'(r), int'(mdl[addr]));
        check(s, "R3 sdo steady in high phase", int'(s), 1);
        end_xfer();
    endtask

    initial begin
        logic [7:0] r;
        bit s;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 reset state
        check(reg_q === '0, "R10 regs zero", int'(reg_q[31:0]), 0);
        check(sdo === 1'b0, "R10 sdo", int'(sdo), 0);
        check(sdo_oe === 1'b0, "R10 oe", int'(sdo_oe), 0);
        cmp_en = 1'b1;

        // R2 R4 R5 single writes and reads at several addresses
        wr1(3, 8'hA5);
        wr1(12, 8'h3C);
        wr1(15, 8'h81);
        rd1(3, "R5 read reg3");
        rd1(12, "R2 read reg12");
        rd1(15, "R2 read reg15");
        rd1(7, "R5 read untouched reg7");

        // R7 status load and write protection
        @(negedge clk);
        cmp_en = 1'b0;
        status_in = 8'h5A;
        status_we = 1'b1;
        @(negedge clk);
        status_we = 1'b0;
        mdl[0] = 8'h5A;
        @(negedge clk);
        cmp_en = 1'b1;
        wr1(0, 8'hFF);
        rd1(0, "R7 status kept");

        // R8 reserved bit set: write is dropped
        begin_xfer();
        byte_xfer(mk_cmd(1'b0, 3, 1'b0, 2'b01), r, s);
        byte_xfer(8'hFF, r, s);
        end_xfer();
        begin_xfer();
        byte_xfer(mk_cmd(1'b0, 12, 1'b0, 2'b10), r, s);
        byte_xfer(8'h00, r, s);
        end_xfer();
        rd1(3, "R8 reg3 unchanged");
        rd1(12, "R8 reg12 unchanged");

        // R9 abort mid byte, then a clean transfer
        begin_xfer();
        byte_xfer(mk_cmd(1'b0, 6, 1'b0, 2'b00), r, s);
        for (int i = 0; i < 4; i++) begin
            logic lo, hi;
            bit_xfer(1'b1, lo, hi);
        end
        end_xfer();
        rd1(6, "R9 aborted write");
        wr1(6, 8'h66);
        rd1(6, "R9 fresh transfer");

        // R6 burst write from register 0, address field ignored, extra byte dropped
        begin_xfer();
        byte_xfer(mk_cmd(1'b0, 5, 1'b1, 2'b00), r, s);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v = 8'(i * 29 + 7);
            byte_xfer(v, r, s);
            if (i != 0) mdl[i] = v;
        end
        byte_xfer(8'hEE, r, s);
        end_xfer();

        // R6 burst read of the whole bank
        begin_xfer();
        byte_xfer(mk_cmd(1'b1, 9, 1'b1, 2'b00), r, s);
        for (int i = 0; i < 16; i++) begin
            byte_xfer(8'h00, r, s);
            check(r === mdl[i], "R6 burst read", int'(r), int'(mdl[i]));
            check(s, "R3 burst sdo steady", int'(s), 1);
        end
        end_xfer();
        rd1(0, "R7 status after burst");
        rd1(15, "R6 last reg");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule